// File: doc/BRIEF.md
# Warp Issue Scheduler

This block sits between a warp instruction supplier and a narrow SIMD execution lane array. Every resident warp has one instruction slot, filled through its own valid/ready load port. An instruction names two source registers and one destination register, all in that warp's private register space. A per-warp scoreboard records which destination registers still have a write outstanding. A slot whose three registers are all free is eligible to issue.

Each cycle a round-robin picker selects at most one eligible warp. The pick starts at the warp after the one that last issued. Issuing empties the slot and marks the destination register busy. A writeback port later frees that register again.

The selected instruction is then fed to a lane array that is narrower than a warp. It therefore occupies the dispatch stage for WARP_SIZE/LANES consecutive cycles, one lane group per cycle. No new issue is made until the final group is on its way. Warps issue in whatever order their operands allow, with no cost for switching from one warp to another.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted and after its release, disp_valid is 0 and every ld_ready bit is 1.
- R2: A warp's slot takes an instruction on a clock edge where ld_valid and ld_ready of that warp are both 1. ld_ready of that warp stays 0 until the slot issues. ld_valid presented while ld_ready is 0 leaves the held instruction unchanged.
- R3: A warp issues only when its slot is full and none of its source A, source B or destination registers is marked pending. A pending destination blocks issue just as a pending source does.
- R4: Issuing marks the destination register of that warp pending. A writeback (wb_valid with wb_warp, wb_reg) seen at a clock edge clears that bit. A warp blocked only by that register shows dispatch lane group 0 at the following edge, not earlier.
- R5: Pending state is kept separately per warp. A writeback to another warp, or a pending register of the same number in another warp, does not affect eligibility.
- R6: Among eligible warps, the one chosen is the first found searching upward from the warp after the last issued one, wrapping from NUM_WARPS-1 to 0. After reset the search starts at warp 0.
- R7: An issue decided in one cycle appears at the next edge as disp_valid=1 with disp_quarter=0. disp_quarter then steps 0,1,2,3 on consecutive cycles (DISP_CYCLES=4 by default). disp_warp and the register fields stay fixed during that run.
- R8: No issue is made while a dispatch is in progress except in its last lane-group cycle. With work waiting, group 0 of the next instruction follows group 3 of the previous one with no idle cycle.
- R9: A slot is free again (ld_ready=1) in the cycle its lane group 0 is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_valid | input | NUM_WARPS | Per-warp instruction offer |
| ld_ready | output | NUM_WARPS | Per-warp slot empty |
| ld_src_a | input | NUM_WARPS*RB | Source A register id, warp w in bits [w*RB +: RB] |
| ld_src_b | input | NUM_WARPS*RB | Source B register id, same packing |
| ld_dst | input | NUM_WARPS*RB | Destination register id, same packing |
| wb_valid | input | 1 | Writeback strobe |
| wb_warp | input | WB | Warp of the written register |
| wb_reg | input | RB | Register id written |
| disp_valid | output | 1 | Lane group being dispatched |
| disp_quarter | output | QB | Index of the lane group, 0 first |
| disp_warp | output | WB | Warp being dispatched |
| disp_src_a | output | RB | Source A of the dispatched instruction |
| disp_src_b | output | RB | Source B of the dispatched instruction |
| disp_dst | output | RB | Destination of the dispatched instruction |

## Verification
On every cycle the assertions check several timing and state rules. Lane groups must step in order with fields held, and a dispatch must start at group 0 on the edge after its issue. No issue may overlap a running dispatch, and an issued warp must have had a full slot with all three registers free. An issued destination must read as pending at group 0, and a slot must be free by then. The round-robin order, including the wrap past the top warp, and the exact cycle at which a writeback unblocks a warp are shown only by the bench's scenarios. The same holds for the isolation of one warp's pending registers from another's and for an offer into a full slot being ignored.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  // Index width for n items, never below one bit.
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wsched_slots.sv
module wsched_slots import wsched_pkg::*; #(
  parameter int NUM_WARPS = 24,
  parameter int RB        = 4,
  parameter int WB        = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_WARPS-1:0]    ld_valid,
  output logic [NUM_WARPS-1:0]    ld_ready,
  input  logic [NUM_WARPS*RB-1:0] ld_src_a,
  input  logic [NUM_WARPS*RB-1:0] ld_src_b,
  input  logic [NUM_WARPS*RB-1:0] ld_dst,
  input  logic                    take_en,
  input  logic [WB-1:0]           take_idx,
  output logic [NUM_WARPS-1:0]    slot_valid,
  output logic [RB-1:0]           slot_a [NUM_WARPS],
  output logic [RB-1:0]           slot_b [NUM_WARPS],
  output logic [RB-1:0]           slot_d [NUM_WARPS]
);
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    logic          v_q, v_d;
    logic          accept, take;
    logic [RB-1:0] a_q, b_q, d_q;

    // Offer is taken only into an empty slot; issue empties a full one.
    always_comb begin
      accept = ld_valid[w] & ~v_q;
      take   = take_en && (take_idx == WB'(w));
      v_d    = v_q;
      if (take)   v_d = 1'b0;
      if (accept) v_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    // Payload registers: no reset, loaded under the accept enable.
    always_ff @(posedge clk) begin
      if (accept) begin
        a_q <= ld_src_a[w*RB +: RB];
        b_q <= ld_src_b[w*RB +: RB];
        d_q <= ld_dst[w*RB +: RB];
      end
    end

    assign ld_ready[w]   = ~v_q;
    assign slot_valid[w] = v_q;
    assign slot_a[w]     = a_q;
    assign slot_b[w]     = b_q;
    assign slot_d[w]     = d_q;
  end
endmodule

// File: rtl/wsched_scoreboard.sv
module wsched_scoreboard import wsched_pkg::*; #(
  parameter int NUM_WARPS = 24,
  parameter int NUM_REGS  = 16,
  parameter int RB        = 4,
  parameter int WB        = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          set_en,
  input  logic [WB-1:0]                 set_warp,
  input  logic [RB-1:0]                 set_reg,
  input  logic                          clr_en,
  input  logic [WB-1:0]                 clr_warp,
  input  logic [RB-1:0]                 clr_reg,
  input  logic [RB-1:0]                 slot_a [NUM_WARPS],
  input  logic [RB-1:0]                 slot_b [NUM_WARPS],
  input  logic [RB-1:0]                 slot_d [NUM_WARPS],
  output logic [NUM_WARPS-1:0]          ops_clear,
  output logic [NUM_WARPS*NUM_REGS-1:0] pending
);
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic [NUM_REGS-1:0] p_q, p_d;

    // Clear first, set second: a new issue outranks a same-edge writeback.
    always_comb begin
      p_d = p_q;
      if (clr_en && (clr_warp == WB'(w))) p_d[clr_reg] = 1'b0;
      if (set_en && (set_warp == WB'(w))) p_d[set_reg] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p_q <= '0;
      else        p_q <= p_d;
    end

    assign ops_clear[w] = ~p_q[slot_a[w]] & ~p_q[slot_b[w]] & ~p_q[slot_d[w]];
    assign pending[w*NUM_REGS +: NUM_REGS] = p_q;
  end
endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick import wsched_pkg::*; #(
  parameter int NUM_WARPS = 24,
  parameter int WB        = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] req,
  input  logic                 advance,
  output logic                 gnt_valid,
  output logic [WB-1:0]        gnt_idx
);
  logic [WB-1:0] ptr_q, ptr_d;
  logic [WB:0]   pos;

  // Cyclic search starting at the pointer.
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    pos       = '0;
    for (int k = 0; k < NUM_WARPS; k++) begin
      pos = {1'b0, ptr_q} + (WB+1)'(k);
      if (pos >= (WB+1)'(NUM_WARPS)) pos = pos - (WB+1)'(NUM_WARPS);
      if (!gnt_valid && req[pos[WB-1:0]]) begin
        gnt_valid = 1'b1;
        gnt_idx   = pos[WB-1:0];
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (advance) begin
      if (gnt_idx == WB'(NUM_WARPS-1)) ptr_d = '0;
      else                              ptr_d = gnt_idx + WB'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/wsched_dispatch.sv
module wsched_dispatch import wsched_pkg::*; #(
  parameter int DISP_CYCLES = 4,
  parameter int QB          = 2,
  parameter int RB          = 4,
  parameter int WB          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WB-1:0] start_warp,
  input  logic [RB-1:0] start_a,
  input  logic [RB-1:0] start_b,
  input  logic [RB-1:0] start_d,
  output logic          can_start,
  output logic          disp_valid,
  output logic [QB-1:0] disp_quarter,
  output logic [WB-1:0] disp_warp,
  output logic [RB-1:0] disp_src_a,
  output logic [RB-1:0] disp_src_b,
  output logic [RB-1:0] disp_dst
);
  logic          v_q, v_d;
  logic [QB-1:0] q_q, q_d;
  logic          last;
  logic [WB-1:0] w_q;
  logic [RB-1:0] a_q, b_q, d_q;

  always_comb begin
    last      = (q_q == QB'(DISP_CYCLES-1));
    can_start = ~v_q | last;
    v_d       = v_q;
    q_d       = q_q;
    if (start) begin
      v_d = 1'b1;
      q_d = '0;
    end else if (v_q) begin
      if (last) v_d = 1'b0;
      else      q_d = q_q + QB'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      q_q <= '0;
    end else begin
      v_q <= v_d;
      q_q <= q_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      w_q <= start_warp;
      a_q <= start_a;
      b_q <= start_b;
      d_q <= start_d;
    end
  end

  assign disp_valid   = v_q;
  assign disp_quarter = q_q;
  assign disp_warp    = w_q;
  assign disp_src_a   = a_q;
  assign disp_src_b   = b_q;
  assign disp_dst     = d_q;
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched import wsched_pkg::*; #(
  parameter int  NUM_WARPS = 24,
  parameter int  NUM_REGS  = 16,
  parameter int  WARP_SIZE = 32,
  parameter int  LANES     = 8,
  localparam int WB          = idx_bits(NUM_WARPS),
  localparam int RB          = idx_bits(NUM_REGS),
  localparam int DISP_CYCLES = WARP_SIZE / LANES,
  localparam int QB          = idx_bits(DISP_CYCLES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_WARPS-1:0]    ld_valid,
  output logic [NUM_WARPS-1:0]    ld_ready,
  input  logic [NUM_WARPS*RB-1:0] ld_src_a,
  input  logic [NUM_WARPS*RB-1:0] ld_src_b,
  input  logic [NUM_WARPS*RB-1:0] ld_dst,
  input  logic                    wb_valid,
  input  logic [WB-1:0]           wb_warp,
  input  logic [RB-1:0]           wb_reg,
  output logic                    disp_valid,
  output logic [QB-1:0]           disp_quarter,
  output logic [WB-1:0]           disp_warp,
  output logic [RB-1:0]           disp_src_a,
  output logic [RB-1:0]           disp_src_b,
  output logic [RB-1:0]           disp_dst
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [NUM_WARPS-1:0]          slot_valid;
  logic [RB-1:0]                 slot_a [NUM_WARPS];
  logic [RB-1:0]                 slot_b [NUM_WARPS];
  logic [RB-1:0]                 slot_d [NUM_WARPS];
  logic [NUM_WARPS-1:0]          ops_clear;
  logic [NUM_WARPS*NUM_REGS-1:0] sb_pending;
  logic [NUM_WARPS-1:0]          eligible;
  logic                          gnt_valid;
  logic [WB-1:0]                 gnt_idx;
  logic                          can_start;
  logic                          issue_en;
  logic [RB-1:0]                 pick_a, pick_b, pick_d;

  assign eligible = slot_valid & ops_clear;
  assign issue_en = gnt_valid & can_start;
  assign pick_a   = slot_a[gnt_idx];
  assign pick_b   = slot_b[gnt_idx];
  assign pick_d   = slot_d[gnt_idx];

  wsched_slots #(.NUM_WARPS(NUM_WARPS), .RB(RB), .WB(WB)) slots_i (
    .clk(clk), .rst_n(rst_sync_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_src_a(ld_src_a), .ld_src_b(ld_src_b), .ld_dst(ld_dst),
    .take_en(issue_en), .take_idx(gnt_idx),
    .slot_valid(slot_valid), .slot_a(slot_a), .slot_b(slot_b), .slot_d(slot_d)
  );

  wsched_scoreboard #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .RB(RB), .WB(WB)) sb_i (
    .clk(clk), .rst_n(rst_sync_n),
    .set_en(issue_en), .set_warp(gnt_idx), .set_reg(pick_d),
    .clr_en(wb_valid), .clr_warp(wb_warp), .clr_reg(wb_reg),
    .slot_a(slot_a), .slot_b(slot_b), .slot_d(slot_d),
    .ops_clear(ops_clear), .pending(sb_pending)
  );

  wsched_rr_pick #(.NUM_WARPS(NUM_WARPS), .WB(WB)) pick_i (
    .clk(clk), .rst_n(rst_sync_n),
    .req(eligible), .advance(issue_en),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  wsched_dispatch #(.DISP_CYCLES(DISP_CYCLES), .QB(QB), .RB(RB), .WB(WB)) disp_i (
    .clk(clk), .rst_n(rst_sync_n),
    .start(issue_en), .start_warp(gnt_idx),
    .start_a(pick_a), .start_b(pick_b), .start_d(pick_d),
    .can_start(can_start),
    .disp_valid(disp_valid), .disp_quarter(disp_quarter), .disp_warp(disp_warp),
    .disp_src_a(disp_src_a), .disp_src_b(disp_src_b), .disp_dst(disp_dst)
  );
endmodule

// File: rtl/wsched_chk.sv
module wsched_chk import wsched_pkg::*; #(
  parameter int  NUM_WARPS = 24,
  parameter int  NUM_REGS  = 16,
  parameter int  WARP_SIZE = 32,
  parameter int  LANES     = 8,
  localparam int WB          = idx_bits(NUM_WARPS),
  localparam int RB          = idx_bits(NUM_REGS),
  localparam int DISP_CYCLES = WARP_SIZE / LANES,
  localparam int QB          = idx_bits(DISP_CYCLES),
  localparam int PB          = idx_bits(NUM_WARPS*NUM_REGS)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_WARPS-1:0]          ld_valid,
  input logic [NUM_WARPS-1:0]          ld_ready,
  input logic                          disp_valid,
  input logic [QB-1:0]                 disp_quarter,
  input logic [WB-1:0]                 disp_warp,
  input logic [RB-1:0]                 disp_dst,
  input logic                          issue_en,
  input logic [WB-1:0]                 gnt_idx,
  input logic [NUM_WARPS-1:0]          slot_valid,
  input logic [NUM_WARPS-1:0]          ops_clear,
  input logic [NUM_WARPS*NUM_REGS-1:0] sb_pending
);
  localparam logic [QB-1:0] LAST_Q = QB'(DISP_CYCLES-1);

  logic [PB-1:0] disp_pos;
  assign disp_pos = PB'(disp_warp) * PB'(NUM_REGS) + PB'(disp_dst);

  // R7: lane groups advance by one with the instruction held
  assert_quarter_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_quarter != LAST_Q |=>
      disp_valid && disp_quarter == $past(disp_quarter) + QB'(1) &&
      $stable(disp_warp) && $stable(disp_dst));

  assert_first_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |=> disp_valid && disp_quarter == '0 && disp_warp == $past(gnt_idx));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> !disp_valid || disp_quarter == LAST_Q);

  assert_issue_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> slot_valid[gnt_idx] && ops_clear[gnt_idx]);

  assert_dst_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_quarter == '0 |-> sb_pending[disp_pos]);

  assert_slot_freed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_quarter == '0 |-> ld_ready[disp_warp]);

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_ld
    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid[w] && ld_ready[w] |=> !ld_ready[w]);
  end
endmodule

bind warp_issue_sched wsched_chk #(
  .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .WARP_SIZE(WARP_SIZE), .LANES(LANES)
) chk_i (
  .clk(clk), .rst_n(rst_sync_n),
  .ld_valid(ld_valid), .ld_ready(ld_ready),
  .disp_valid(disp_valid), .disp_quarter(disp_quarter),
  .disp_warp(disp_warp), .disp_dst(disp_dst),
  .issue_en(issue_en), .gnt_idx(gnt_idx),
  .slot_valid(slot_valid), .ops_clear(ops_clear), .sb_pending(sb_pending)
);

// File: tb/warp_issue_sched_tb_top.sv
`timescale 1ns/1ps
module warp_issue_sched_tb_top;
  localparam int NW = 24;
  localparam int RB = 4;
  localparam int WB = 5;
  localparam int QB = 2;

  logic             clk;
  logic             rst_n;
  logic [NW-1:0]    ld_valid;
  logic [NW-1:0]    ld_ready;
  logic [NW*RB-1:0] ld_src_a, ld_src_b, ld_dst;
  logic             wb_valid;
  logic [WB-1:0]    wb_warp;
  logic [RB-1:0]    wb_reg;
  logic             disp_valid;
  logic [QB-1:0]    disp_quarter;
  logic [WB-1:0]    disp_warp;
  logic [RB-1:0]    disp_src_a, disp_src_b, disp_dst;

  int n_checks = 0;
  int n_err    = 0;

  warp_issue_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_src_a(ld_src_a), .ld_src_b(ld_src_b), .ld_dst(ld_dst),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .disp_valid(disp_valid), .disp_quarter(disp_quarter), .disp_warp(disp_warp),
    .disp_src_a(disp_src_a), .disp_src_b(disp_src_b), .disp_dst(disp_dst)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Stimulus table: six warps offered on one edge; rank = expected issue order
  localparam int TN = 6;
  localparam int TW [TN] = '{3, 7, 1, 20, 23, 12};
  localparam int TA [TN] = '{1, 2, 3, 4, 5, 6};
  localparam int TB [TN] = '{7, 8, 9, 10, 11, 12};
  localparam int TD [TN] = '{13, 14, 15, 0, 1, 2};
  localparam int TR [TN] = '{1, 2, 0, 4, 5, 3};

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic offer(input int w, input int a, input int b, input int d);
    ld_valid[w]          = 1'b1;
    ld_src_a[w*RB +: RB] = RB'(a);
    ld_src_b[w*RB +: RB] = RB'(b);
    ld_dst[w*RB +: RB]   = RB'(d);
  endtask

  task automatic writeback(input int w, input int r);
    wb_valid = 1'b1;
    wb_warp  = WB'(w);
    wb_reg   = RB'(r);
    step();
    wb_valid = 1'b0;
  endtask

  // Expect lane group 0 of the given instruction in the current cycle.
  task automatic expect_start(input string req, input int w, input int a, input int b, input int d);
    bit ok;
    ok = disp_valid && disp_quarter == 0 && int'(disp_warp) == w &&
         int'(disp_src_a) == a && int'(disp_src_b) == b && int'(disp_dst) == d;
    check(ok, req, disp_valid ? int'(disp_warp) : -1, w);
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    ld_valid = '0;
    wb_valid = 1'b0;
    repeat (2) step();
    check(!disp_valid && ld_ready == '1, "R1 in reset", int'(disp_valid), 0);
    rst_n = 1'b1;
    repeat (3) step();
    check(!disp_valid && ld_ready == '1, "R1 after release", int'(ld_ready == '1), 1);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    ld_src_a = '0; ld_src_b = '0; ld_dst = '0;
    wb_warp  = '0; wb_reg = '0;
    do_reset();

    // ---- table walk: all six offered together, issued in R6 order ----
    for (int i = 0; i < TN; i++) offer(TW[i], TA[i], TB[i], TD[i]);
    step();
    ld_valid = '0;
    check(ld_ready[12] == 1'b0, "R2 slot held", int'(ld_ready[12]), 0);
    step();
    for (int k = 0; k < TN; k++) begin
      for (int i = 0; i < TN; i++)
        if (TR[i] == k) expect_start("R6 table order", TW[i], TA[i], TB[i], TD[i]);
      repeat (4) step();
    end
    check(!disp_valid, "R8 idle after table", int'(disp_valid), 0);

    // ---- R6/R7/R8: pointer after warp 4, lane group stepping ----
    do_reset();
    offer(4, 1, 2, 3);
    step();
    ld_valid = '0;
    step();
    expect_start("R7 start warp4", 4, 1, 2, 3);
    offer(2, 5, 6, 7);
    offer(9, 8, 9, 10);
    step();
    ld_valid = '0;
    check(disp_valid && disp_quarter == 1 && disp_warp == 4, "R7 group1", int'(disp_quarter), 1);
    step();
    check(disp_valid && disp_quarter == 2 && disp_warp == 4, "R7 group2", int'(disp_quarter), 2);
    step();
    check(disp_valid && disp_quarter == 3 && disp_warp == 4, "R7 group3", int'(disp_quarter), 3);
    step();
    expect_start("R6 R8 warp9 back-to-back", 9, 8, 9, 10);
    repeat (4) step();
    expect_start("R6 wrap to warp2", 2, 5, 6, 7);

    // ---- R6: wrap after the top warp ----
    do_reset();
    offer(23, 0, 0, 1);
    step();
    ld_valid = '0;
    step();
    expect_start("R6 warp23", 23, 0, 0, 1);
    offer(0, 2, 3, 4);
    offer(22, 5, 6, 7);
    step();
    ld_valid = '0;
    repeat (3) step();
    expect_start("R6 after 23 goes to 0", 0, 2, 3, 4);
    repeat (4) step();
    expect_start("R6 then 22", 22, 5, 6, 7);

    // ---- R3/R4/R5/R2: read-after-write blocking and release ----
    do_reset();
    offer(5, 1, 1, 2);
    step();
    ld_valid = '0;
    step();
    expect_start("R7 warp5 first", 5, 1, 1, 2);
    check(ld_ready[5] == 1'b1, "R9 slot free at group0", int'(ld_ready[5]), 1);
    offer(5, 2, 3, 4);
    step();
    ld_valid = '0;
    check(ld_ready[5] == 1'b0, "R2 ready low while held", int'(ld_ready[5]), 0);
    repeat (6) step();
    check(!disp_valid, "R3 source pending blocks", int'(disp_valid), 0);
    offer(5, 7, 7, 7);
    step();
    ld_valid = '0;
    writeback(4, 2);
    repeat (3) step();
    check(!disp_valid, "R5 other warp writeback", int'(disp_valid), 0);
    writeback(5, 2);
    check(!disp_valid, "R4 not before next edge", int'(disp_valid), 0);
    step();
    expect_start("R4 R2 released, original kept", 5, 2, 3, 4);

    // ---- R5/R3: destination 4 of warp 5 is pending now ----
    offer(5, 0, 1, 4);
    offer(6, 4, 4, 5);
    step();
    ld_valid = '0;
    repeat (3) step();
    expect_start("R5 warp6 unaffected", 6, 4, 4, 5);
    repeat (4) step();
    check(!disp_valid, "R3 pending destination blocks", int'(disp_valid), 0);
    writeback(5, 4);
    step();
    expect_start("R3 R4 released after writeback", 5, 0, 1, 4);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule